// File: doc/BRIEF.md
# Bit-field read-modify-write unit

This block applies a 16-bit immediate mask to a destination word and writes the outcome back. It has two operations. A clear turns off every destination bit that is 1 in the mask. An AND-with-immediate is not a separate datapath: the unit inverts the immediate and runs that value through the clear path. The bits that are 1 in this effective clear mask are also tested before the write. The carry flag records whether all of them were 1 in the destination.

There are three kinds of destination. A word in memory is handled as a two-access sequence on a simple synchronous memory port: one read, then one write to the same address. A register operand arrives on an input bus, and its result comes back one cycle later on an output bus with a write strobe. The unit's own status register can also be the destination. In that case the mask clears status bits directly and the carry rule does not apply. The status register comes out of reset holding both interrupt-mask bits set, and its reserved bits always read zero.

Top module: `bfrmw_unit`

## Requirements
- R1: With `op_andi`=0 (clear), the value written is the destination AND the inverse of `imm`.
- R2: With `op_andi`=1 (AND-with-immediate), the effective clear mask is the inverse of `imm`, so the value written is the destination AND `imm`. For example, a destination of 0xC3FF with `imm`=0x5555 writes back 0x4155 and clears carry.
- R3: For memory and register destinations, carry (`sr_out` bit 0) becomes 1 when every bit that is 1 in the effective clear mask is also 1 in the destination, and 0 otherwise. An all-zero effective mask sets carry.
- R4: `dst_sel`=0 selects memory. `mem_re` is high for exactly the one cycle after the start edge, with `mem_addr` equal to `addr`. Read data is taken one cycle after that. In the next cycle `mem_we` and `done` are high together, with `mem_wdata` holding the result and the same address.
- R5: `dst_sel`=1 selects the register operand taken from `reg_in`. In the cycle after the start edge, `reg_out` holds the result and both `reg_we` and `done` are high, each for one cycle.
- R6: `dst_sel`=2 selects the status register. `sr_out` becomes `sr_out` AND the inverse of the effective mask, in the cycle after the start edge. Bits 14 to 10 always read zero, and carry is only cleared through its mask bit.
- R7: A memory or register operation changes no `sr_out` bit other than bit 0.
- R8: `busy` is high while a memory sequence is reading. A `start` that arrives while `busy` is high, or one with `dst_sel`=3, is ignored. It causes no read, no register write, no `done` and no status change, and it does not disturb the sequence already running.
- R9: While reset is held, `sr_out` is 0x0300 and `busy`, `done`, `reg_we`, `mem_re` and `mem_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation |
| op_andi | input | 1 | 0 = clear with mask, 1 = AND with immediate |
| dst_sel | input | 2 | 0 memory, 1 register, 2 status register, 3 none |
| imm | input | 16 | Immediate value |
| addr | input | 8 | Memory destination address |
| reg_in | input | 16 | Register operand value |
| reg_out | output | 16 | Register result |
| reg_we | output | 1 | Register result strobe |
| sr_out | output | 16 | Status register |
| busy | output | 1 | Memory sequence in its read phase |
| done | output | 1 | Operation completes this cycle |
| mem_addr | output | 8 | Memory address |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after `mem_re` |

## Verification
The held mask and the sequencer state matter only for the write of a memory sequence. If either is corrupted, the wrong word or the wrong address shows on the memory port two cycles after the start edge, or a stray or missing `mem_we` pulse appears there. A carry test that goes wrong shows in `sr_out` bit 0 in the same cycle as `done`. A status register that goes wrong shows at once on `sr_out`, either as a set reserved bit or as a change to bits 15 to 1 after a non-status operation. The bench sweeps many operand and immediate pairs through each destination and covers the all-zero and all-one masks. It also fires a conflicting request into a running sequence.

// File: rtl/bfrmw_pkg.sv
package bfrmw_pkg;

  typedef enum logic [1:0] {
    DST_MEM  = 2'd0,
    DST_REG  = 2'd1,
    DST_STAT = 2'd2,
    DST_NONE = 2'd3
  } dst_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_READ = 2'd1,
    SQ_CAPT = 2'd2
  } sq_e;

  // status register bit positions
  localparam int SRB_LOOP = 15;
  localparam int SRB_IM1  = 9;
  localparam int SRB_IM0  = 8;
  localparam int SRB_SCL  = 7;
  localparam int SRB_LIM  = 6;
  localparam int SRB_EXT  = 5;
  localparam int SRB_UNN  = 4;
  localparam int SRB_NEG  = 3;
  localparam int SRB_ZER  = 2;
  localparam int SRB_OVF  = 1;
  localparam int SRB_C    = 0;

  localparam logic [15:0] SR_RSVD = 16'h7C00;

endpackage

// File: rtl/bfrmw_maskgen.sv
module bfrmw_maskgen #(
  parameter int DW = 16
) (
  input  logic          andi,
  input  logic [DW-1:0] imm,
  output logic [DW-1:0] mask
);
  // AND-with-immediate reuses the clear path with the inverted value
  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign mask[b] = imm[b] ^ andi;
  end
endmodule

// File: rtl/bfrmw_bitop.sv
module bfrmw_bitop #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] opnd,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] res,
  output logic          all_set
);
  logic [DW-1:0] miss;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign res[b]  = opnd[b] & ~mask[b];
    assign miss[b] = mask[b] & ~opnd[b];
  end

  assign all_set = ~|miss;
endmodule

// File: rtl/bfrmw_seq.sv
module bfrmw_seq
  import bfrmw_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          capt,
  output logic          busy
);
  sq_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= SQ_IDLE;
      mem_re   <= 1'b0;
      mem_addr <= '0;
    end else begin
      mem_re <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (launch) begin
          st_q     <= SQ_READ;
          mem_re   <= 1'b1;
          mem_addr <= addr_in;
        end
        SQ_READ: st_q <= SQ_CAPT;
        SQ_CAPT: st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign capt = (st_q == SQ_CAPT);
  assign busy = (st_q != SQ_IDLE);

  // R8: one read per sequence, never back to back
  a_r8_single_read: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_re);
  // R4: read data is captured one cycle after the read strobe
  a_r4_capt_after_read: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> capt);
endmodule

// File: rtl/bfrmw_stat.sv
module bfrmw_stat
  import bfrmw_pkg::*;
#(
  parameter int          DW       = 16,
  parameter logic [15:0] SR_RESET = 16'h0300
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_en,
  input  logic [DW-1:0] clr_mask,
  input  logic          c_en,
  input  logic          c_val,
  output logic [DW-1:0] sr_q
);
  localparam logic [DW-1:0] RSVD  = DW'(SR_RSVD);
  localparam logic [DW-1:0] RST_V = DW'(SR_RESET) & ~RSVD;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= RST_V;
    end else if (clr_en) begin
      sr_q <= sr_q & ~clr_mask & ~RSVD;
    end else if (c_en) begin
      sr_q[SRB_C] <= c_val;
    end
  end

  // R6: reserved field never reads one
  a_r6_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    (sr_q & RSVD) == '0);
  // R6: a direct status operation never sets a bit
  a_r6_no_set: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> (sr_q & ~$past(sr_q)) == '0);
  // R7: without a direct status write, only carry may move
  a_r7_upper_hold: assert property (@(posedge clk) disable iff (rst)
    !clr_en |=> sr_q[DW-1:1] == $past(sr_q[DW-1:1]));
endmodule

// File: rtl/bfrmw_unit.sv
module bfrmw_unit
  import bfrmw_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          AW       = 8,
  parameter logic [15:0] SR_RESET = 16'h0300
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op_andi,
  input  logic [1:0]    dst_sel,
  input  logic [DW-1:0] imm,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] reg_in,
  output logic [DW-1:0] reg_out,
  output logic          reg_we,
  output logic [DW-1:0] sr_out,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  dst_e          dsel;
  logic          accept, acc_mem, acc_reg, acc_sr;
  logic          capt;
  logic [DW-1:0] mask_now, mask_q, use_mask, use_opnd, res;
  logic          all_set;

  assign dsel    = dst_e'(dst_sel);
  assign accept  = start & ~busy & (dsel != DST_NONE);
  assign acc_mem = accept & (dsel == DST_MEM);
  assign acc_reg = accept & (dsel == DST_REG);
  assign acc_sr  = accept & (dsel == DST_STAT);

  bfrmw_maskgen #(.DW(DW)) u_mask (
    .andi (op_andi),
    .imm  (imm),
    .mask (mask_now)
  );

  bfrmw_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .launch   (acc_mem),
    .addr_in  (addr),
    .mem_addr (mem_addr),
    .mem_re   (mem_re),
    .capt     (capt),
    .busy     (busy)
  );

  // mask is held across the memory read so inputs may change meanwhile
  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else if (acc_mem) mask_q <= mask_now;
  end

  assign use_mask = capt ? mask_q    : mask_now;
  assign use_opnd = capt ? mem_rdata : reg_in;

  bfrmw_bitop #(.DW(DW)) u_bitop (
    .opnd    (use_opnd),
    .mask    (use_mask),
    .res     (res),
    .all_set (all_set)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_out   <= '0;
      reg_we    <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      done      <= 1'b0;
    end else begin
      reg_we <= acc_reg;
      mem_we <= capt;
      done   <= acc_reg | acc_sr | capt;
      if (acc_reg) reg_out   <= res;
      if (capt)    mem_wdata <= res;
    end
  end

  bfrmw_stat #(.DW(DW), .SR_RESET(SR_RESET)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .clr_en   (acc_sr),
    .clr_mask (mask_now),
    .c_en     (acc_reg | capt),
    .c_val    (all_set),
    .sr_q     (sr_out)
  );

  // R4: the write lands two cycles after the read, at the same address
  a_r4_write_follows: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> ##2 mem_we);
  a_r4_same_addr: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_addr == $past(mem_addr, 2));
  // R5: every result strobe is reported as completion
  a_r5_we_done: assert property (@(posedge clk) disable iff (rst)
    (reg_we || mem_we) |-> done);
endmodule

// File: tb/tb_bfrmw_unit.sv
`timescale 1ns/1ps
module tb_bfrmw_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, op_andi = 1'b0;
  logic [1:0]  dst_sel = 2'd0;
  logic [15:0] imm = '0, reg_in = '0;
  logic [7:0]  addr = '0;
  logic [15:0] reg_out, sr_out, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        reg_we, busy, done, mem_re, mem_we;
  logic [7:0]  mem_addr;
  logic [15:0] mem [256];
  logic [15:0] sr_model;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bfrmw_unit dut (
    .clk(clk), .rst(rst), .start(start), .op_andi(op_andi), .dst_sel(dst_sel),
    .imm(imm), .addr(addr), .reg_in(reg_in), .reg_out(reg_out), .reg_we(reg_we),
    .sr_out(sr_out), .busy(busy), .done(done), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] eff_mask(input logic a, input logic [15:0] v);
    return a ? ~v : v;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // register destination, R1 R2 R3 R5 R7
  task automatic op_reg(input logic a, input logic [15:0] v, input logic [15:0] d);
    logic [15:0] m, e;
    m = eff_mask(a, v);
    e = d & ~m;
    @(negedge clk);
    start = 1; op_andi = a; dst_sel = 2'd1; imm = v; reg_in = d;
    @(negedge clk);
    start = 0;
    chk(reg_out == e, a ? "R2" : "R1", reg_out, e);
    chk(reg_we && done, "R5", {reg_we, done}, 2'b11);
    sr_model[0] = ((d & m) == m);
    chk(sr_out == sr_model, "R3", sr_out, sr_model);
  endtask

  // memory destination, R4; intrude exercises R8
  task automatic op_mem(input logic a, input logic [15:0] v, input logic [7:0] ad, input bit intrude);
    logic [15:0] m, d, e;
    m = eff_mask(a, v);
    d = mem[ad];
    e = d & ~m;
    @(negedge clk);
    start = 1; op_andi = a; dst_sel = 2'd0; imm = v; addr = ad;
    @(negedge clk);
    start = 0;
    chk(mem_re && mem_addr == ad && busy, "R4", {mem_re, mem_addr}, {1'b1, ad});
    if (intrude) begin
      start = 1; dst_sel = 2'd1; imm = ~v; op_andi = ~a; reg_in = 16'hFFFF; addr = ~ad;
    end
    @(negedge clk);
    chk(!mem_we && !done && !mem_re, "R4", {mem_we, done, mem_re}, 3'b000);
    if (intrude) chk(!reg_we, "R8", reg_we, 0);
    @(negedge clk);
    start = 0;
    chk(mem_we && done && mem_addr == ad, "R4", {mem_we, done, mem_addr}, {2'b11, ad});
    chk(mem_wdata == e, a ? "R2" : "R1", mem_wdata, e);
    if (intrude) chk(!reg_we && !mem_re, "R8", {reg_we, mem_re}, 2'b00);
    sr_model[0] = ((d & m) == m);
    chk(sr_out == sr_model, "R3", sr_out, sr_model);
    @(negedge clk);
    chk(mem[ad] == e && !mem_we, "R4", mem[ad], e);
  endtask

  // status destination, R6
  task automatic op_sr(input logic a, input logic [15:0] v);
    logic [15:0] m;
    m = eff_mask(a, v);
    @(negedge clk);
    start = 1; op_andi = a; dst_sel = 2'd2; imm = v;
    @(negedge clk);
    start = 0;
    sr_model = sr_model & ~m & 16'h83FF;
    chk(sr_out == sr_model && done && !reg_we, "R6", sr_out, sr_model);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 16'(k * 16'h3B1D) ^ 16'hC3FF;
    mem[8'hA0] = 16'hC3FF;
    sr_model = 16'h0300;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(sr_out == 16'h0300, "R9", sr_out, 16'h0300);
    chk(!busy && !done && !reg_we && !mem_re && !mem_we, "R9",
        {busy, done, reg_we, mem_re, mem_we}, 0);
    rst = 0;
    @(negedge clk);

    // R2 worked example through memory
    op_mem(1'b1, 16'h5555, 8'hA0, 0);
    chk(mem[8'hA0] == 16'h4155 && sr_out[0] == 1'b0, "R2", mem[8'hA0], 16'h4155);

    // R3 all-zero effective masks set carry; full masks
    op_reg(1'b0, 16'h0000, 16'h1234);
    op_reg(1'b1, 16'hFFFF, 16'h0000);
    op_reg(1'b0, 16'hFFFF, 16'hFFFF);
    op_reg(1'b0, 16'hFFFF, 16'hFFFE);
    op_reg(1'b1, 16'h0000, 16'h8001);

    // register sweep, R1 R2 R3 R7
    for (int i = 0; i < 600; i++) begin
      op_reg(1'(i), 16'(i * 16'h7F4B + 3) & 16'((i % 3 == 0) ? 16'hFFFF : 16'h00F0),
             16'(i * 16'h9E37) ^ 16'h5A5A);
      if (i % 7 == 0) op_reg(1'(i), 16'(i * 16'h1111), 16'hFFFF);
    end

    // memory sweep, R4, with intrusions for R8
    for (int i = 0; i < 128; i++)
      op_mem(1'(i >> 1), 16'(i * 16'h2D3F), 8'(i * 37), i % 4 == 1);

    // R8: null destination does nothing
    @(negedge clk);
    start = 1; dst_sel = 2'd3; imm = 16'hFFFF; op_andi = 0; reg_in = 16'hAAAA;
    @(negedge clk);
    start = 0;
    chk(!done && !reg_we && !mem_re && sr_out == sr_model, "R8",
        {done, reg_we, mem_re, sr_out}, {3'b000, sr_model});

    // status register destination, R6
    op_reg(1'b0, 16'h0000, 16'h0000);
    op_sr(1'b0, 16'h7C00);
    op_sr(1'b1, 16'hFEFF);
    op_sr(1'b0, 16'h0002);
    op_sr(1'b0, 16'h0001);
    op_sr(1'b0, 16'h0200);
    op_reg(1'b0, 16'h00F0, 16'h00F0);
    chk(sr_out == 16'h0001, "R7", sr_out, 16'h0001);
    op_sr(1'b1, 16'hFFFE);
    chk(sr_out == 16'h0000, "R6", sr_out, 16'h0000);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule